// File: doc/BRIEF.md
# Parallel NOR Flash Bus Write Qualifier with Identification Readout

This block sits at the pin side of a byte-wide parallel NOR flash model. It samples the active-low chip select, output enable and write strobe on the system clock and decides which bus cycles are genuine writes. Each accepted write is handed to a downstream command decoder as a one-clock pulse that carries the address and the data byte. Writes are held off after reset until the write strobe has been seen inactive, and also while a digital low-supply indicator is asserted. A strobe that stays low for too few clocks is treated as noise and dropped.

The block also keeps one protection flag per sector. The flags change only through dedicated set and clear strobes, which are honoured only while a high-voltage indicator is active. A write that the decoder marks as a program or erase target and that lands in a protected sector is refused and flagged. When an identification input is active, read cycles return a manufacturer code, a device code or the protection state of a sector, depending on a few low address bits.

Top module: `nor_flash_front`

## Requirements
- R1: A write cycle begins only on a clock where chip select is low, write strobe is low and output enable is high; if chip select goes high or output enable goes low while the write strobe is still low, the cycle is abandoned and produces no output pulse.
- R2: A write counts only if the begin condition of R1 held on at least MIN_LOW consecutive clocks (default 3) before the write strobe is sampled high again; a shorter low phase produces nothing.
- R3: An accepted write raises `cmd_valid` for exactly one clock, in the cycle after the clock that samples the write strobe high. `cmd_addr` holds the address sampled on the first low clock and `cmd_data` holds the data sampled on the clock that saw the strobe high.
- R4: After reset, no write is accepted until the write strobe has been sampled high at least once, so a low phase already in progress when reset is released is ignored; `dec_hold` stays high until then.
- R5: While `supply_low` is high, no write is accepted, a low phase in progress is abandoned and `dec_hold` is high; after it clears, the write strobe must be sampled high once more before a new write can begin.
- R6: There are 8 protection flags, all clear after reset, and the sector number is `addr[16:14]`. A clock with `hv_active` and `prot_set` high sets that sector's flag, and one with `hv_active` and `prot_clr` high clears it, with set taking priority. Both strobes are ignored while `hv_active` is low.
- R7: An accepted write with `modify_req` high whose latched address falls in a protected sector raises `cmd_reject` for one clock instead of `cmd_valid`; with `modify_req` low the write gives `cmd_valid` whatever the protection state is.
- R8: With `id_mode` high, chip select low and output enable low, the next clock gives `id_drive` high and `rd_data` as follows, with `addr[6]` low: `addr[1:0]`=00 gives 01h, 01 gives 20h, 10 gives 01h if the sector of `addr[16:14]` is protected and 00h if not, and 11 gives 00h. With `addr[6]` high the result is 00h.
- R9: If no identification read took place on the previous clock, `id_drive` is low and `rd_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write strobe |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data byte |
| supply_low | input | 1 | Low-supply indicator, high means locked out |
| hv_active | input | 1 | High-voltage indicator that enables protection changes |
| prot_set | input | 1 | Set the protection flag of sector addr[16:14] |
| prot_clr | input | 1 | Clear the protection flag of sector addr[16:14] |
| id_mode | input | 1 | Identification readout selected |
| modify_req | input | 1 | From the decoder: the next write is a program or erase target |
| cmd_valid | output | 1 | One-clock pulse for an accepted write |
| cmd_addr | output | 17 | Latched write address |
| cmd_data | output | 8 | Latched write data |
| cmd_reject | output | 1 | One-clock pulse for a write refused by protection |
| dec_hold | output | 1 | Holds the command decoder in reset (array-read state) |
| rd_data | output | 8 | Identification read data |
| id_drive | output | 1 | High when rd_data carries an identification value |

## Verification
A wrong lockout flag shows at the ports straight away: `dec_hold` is compared on every clock, and an unwanted or missing `cmd_valid` shows one clock after the strobe rises. A pulse counter that is off by one shows as an accepted or dropped write at the MIN_LOW boundary, and a wrong address latch shows in `cmd_addr`, because the bench changes the address after the first low clock. A corrupted protection flag cannot be seen until the next identification read or modify write to that sector, so the bench reads protection status right after each strobe.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

  typedef enum logic [1:0] {
    ID_MFR  = 2'd0,
    ID_DEV  = 2'd1,
    ID_PROT = 2'd2,
    ID_NONE = 2'd3
  } id_sel_e;

  // Select which identification value a read returns from the low address bits.
  function automatic id_sel_e pick_id(input logic a6, input logic a1, input logic a0);
    if (a6) return ID_NONE;
    case ({a1, a0})
      2'b00:   return ID_MFR;
      2'b01:   return ID_DEV;
      2'b10:   return ID_PROT;
      default: return ID_NONE;
    endcase
  endfunction

  function automatic logic [7:0] id_value(input id_sel_e sel, input logic prot,
                                          input logic [7:0] mfr, input logic [7:0] dev);
    case (sel)
      ID_MFR:  return mfr;
      ID_DEV:  return dev;
      ID_PROT: return prot ? 8'h01 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nfe_strobe_qual.sv
module nfe_strobe_qual #(
  parameter int ADDR_W  = 17,
  parameter int MIN_LOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] addr,
  output logic              fire,
  output logic [ADDR_W-1:0] addr_q,
  output logic              armed
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

  logic             armed_q;
  logic [CNT_W-1:0] run_q;
  logic             cyc_on;
  logic             live;
  logic             start;

  assign cyc_on = !chip_sel_n && !wr_en_n && out_en_n;
  assign live   = armed_q && !supply_low;
  assign start  = live && cyc_on && (run_q == '0);
  assign fire   = live && wr_en_n && (run_q >= CNT_MAX);
  assign armed  = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      run_q   <= '0;
      addr_q  <= '0;
    end else begin
      if (supply_low)   armed_q <= 1'b0;
      else if (wr_en_n) armed_q <= 1'b1;

      if (live && cyc_on) run_q <= (run_q == CNT_MAX) ? run_q : run_q + 1'b1;
      else                run_q <= '0;

      if (start) addr_q <= addr;
    end
  end

  AST_LOWSUP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_low) |-> !armed_q); // R5

endmodule

// File: rtl/nfe_sector_guard.sv
module nfe_sector_guard #(
  parameter int SECT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hv_active,
  input  logic                    prot_set,
  input  logic                    prot_clr,
  input  logic [SECT_W-1:0]       sector,
  output logic [(1<<SECT_W)-1:0]  prot_flags
);
  localparam int NSECT = 1 << SECT_W;

  logic [NSECT-1:0] prot_q;

  for (genvar s = 0; s < NSECT; s++) begin : g_flag
    logic hit;
    assign hit = hv_active && (sector == SECT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                prot_q[s] <= 1'b0;
      else if (hit && prot_set)  prot_q[s] <= 1'b1;
      else if (hit && prot_clr)  prot_q[s] <= 1'b0;
    end
  end

  assign prot_flags = prot_q;

  AST_PROT_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $past(hv_active)); // R6

endmodule

// File: rtl/nfe_id_resp.sv
module nfe_id_resp #(
  parameter int         SECT_W   = 3,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_req,
  input  logic                   a6,
  input  logic                   a1,
  input  logic                   a0,
  input  logic [SECT_W-1:0]      sector,
  input  logic [(1<<SECT_W)-1:0] prot_flags,
  output logic [7:0]             rd_data,
  output logic                   id_drive
);
  import nfe_pkg::*;

  id_sel_e    sel;
  logic [7:0] value;

  assign sel   = pick_id(a6, a1, a0);
  assign value = id_value(sel, prot_flags[sector], MFR_CODE, DEV_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      id_drive <= 1'b0;
    end else begin
      rd_data  <= rd_req ? value : 8'h00;
      id_drive <= rd_req;
    end
  end

endmodule

// File: rtl/nor_flash_front.sv
module nor_flash_front #(
  parameter int         ADDR_W   = 17,
  parameter int         DATA_W   = 8,
  parameter int         SECT_W   = 3,
  parameter int         MIN_LOW  = 3,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              supply_low,
  input  logic              hv_active,
  input  logic              prot_set,
  input  logic              prot_clr,
  input  logic              id_mode,
  input  logic              modify_req,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_reject,
  output logic              dec_hold,
  output logic [7:0]        rd_data,
  output logic              id_drive
);
  localparam int NSECT = 1 << SECT_W;

  logic              fire;
  logic              armed;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [NSECT-1:0]  prot_flags;
  logic              tgt_locked;
  logic              id_rd_req;

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  nfe_strobe_qual #(.ADDR_W(ADDR_W), .MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .supply_low(supply_low), .addr(addr),
    .fire(fire), .addr_q(wr_addr_q), .armed(armed)
  );

  nfe_sector_guard #(.SECT_W(SECT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .hv_active(hv_active), .prot_set(prot_set),
    .prot_clr(prot_clr), .sector(sector_of(addr)), .prot_flags(prot_flags)
  );

  assign id_rd_req = id_mode && !chip_sel_n && !out_en_n;

  nfe_id_resp #(.SECT_W(SECT_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk(clk), .rst_n(rst_n), .rd_req(id_rd_req), .a6(addr[6]), .a1(addr[1]),
    .a0(addr[0]), .sector(sector_of(addr)), .prot_flags(prot_flags),
    .rd_data(rd_data), .id_drive(id_drive)
  );

  assign tgt_locked = modify_req && prot_flags[sector_of(wr_addr_q)];
  assign dec_hold   = !armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      cmd_reject <= 1'b0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
    end else begin
      cmd_valid  <= fire && !tgt_locked;
      cmd_reject <= fire && tgt_locked;
      if (fire) begin
        cmd_addr <= wr_addr_q;
        cmd_data <= din;
      end
    end
  end

  AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(wr_en_n) && !$past(wr_en_n, 2))); // R3
  AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R3
  AST_LOWSUP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> (!cmd_valid && !cmd_reject)); // R5
  AST_REJECT_NEEDS_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> $past(modify_req)); // R7
  AST_ID_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    id_drive |-> $past(id_mode)); // R8
  AST_NO_ID_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(id_mode) |-> (rd_data == 8'h00 && !id_drive)); // R9

endmodule

// File: tb/test_nor_flash_front.sv
module test_nor_flash_front;
  localparam int MIN_LOW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic        supply_low = 1'b0, hv_active = 1'b0, prot_set = 1'b0, prot_clr = 1'b0;
  logic        id_mode = 1'b0, modify_req = 1'b0;
  logic        cmd_valid, cmd_reject, dec_hold, id_drive;
  logic [16:0] cmd_addr;
  logic [7:0]  cmd_data, rd_data;

  int checks = 0;
  int errors = 0;
  int valid_seen = 0;
  int reject_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nor_flash_front i_nor_flash_front (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .addr(addr), .din(din), .supply_low(supply_low),
    .hv_active(hv_active), .prot_set(prot_set), .prot_clr(prot_clr),
    .id_mode(id_mode), .modify_req(modify_req), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_reject(cmd_reject),
    .dec_hold(dec_hold), .rd_data(rd_data), .id_drive(id_drive)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising clock edge.
  bit          m_armed = 0;
  int          m_run = 0;
  int          m_addr = 0;
  bit          m_prot [8];
  bit          e_valid = 0, e_reject = 0, e_idd = 0;
  int          e_addr = 0, e_data = 0, e_rd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_run = 0; m_addr = 0;
      foreach (m_prot[i]) m_prot[i] = 0;
      e_valid = 0; e_reject = 0; e_idd = 0; e_addr = 0; e_data = 0; e_rd = 0;
    end else begin
      bit ok, begin_cond, accept, locked, rdq;
      int sec, idsec;
      ok = m_armed && !supply_low;
      begin_cond = !chip_sel_n && !wr_en_n && out_en_n;
      accept = ok && wr_en_n && (m_run >= MIN_LOW);
      locked = modify_req && m_prot[m_addr / 16384];
      e_valid = accept && !locked;
      e_reject = accept && locked;
      if (accept) begin e_addr = m_addr; e_data = din; end
      rdq = id_mode && !chip_sel_n && !out_en_n;
      idsec = addr / 16384;
      e_idd = rdq;
      e_rd = 0;
      if (rdq && !addr[6]) begin
        if (addr[1:0] == 2'b00) e_rd = 8'h01;
        else if (addr[1:0] == 2'b01) e_rd = 8'h20;
        else if (addr[1:0] == 2'b10) e_rd = m_prot[idsec] ? 1 : 0;
      end
      if (ok && begin_cond && m_run == 0) m_addr = addr;
      if (ok && begin_cond) m_run = (m_run < MIN_LOW) ? m_run + 1 : m_run;
      else m_run = 0;
      sec = addr / 16384;
      if (hv_active && prot_set) m_prot[sec] = 1;
      else if (hv_active && prot_clr) m_prot[sec] = 0;
      if (supply_low) m_armed = 0;
      else if (wr_en_n) m_armed = 1;
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 cmd_valid", cmd_valid, e_valid);
      chk("R7 cmd_reject", cmd_reject, e_reject);
      chk("R4 dec_hold", dec_hold, !m_armed);
      chk("R8 id_drive", id_drive, e_idd);
      chk("R8 rd_data", rd_data, e_rd);
      if (e_valid || e_reject) begin
        chk("R3 cmd_addr", cmd_addr, e_addr);
        chk("R3 cmd_data", cmd_data, e_data);
      end
      if (cmd_valid) valid_seen++;
      if (cmd_reject) reject_seen++;
    end
  end

  task automatic idle();
    chip_sel_n = 1; out_en_n = 1; wr_en_n = 1; modify_req = 0;
  endtask

  // Low phase of nlow sampled clocks; the address moves after the first low clock.
  task automatic wr(input logic [16:0] a, input logic [7:0] d, input int nlow, input bit m);
    @(negedge clk);
    chip_sel_n = 0; out_en_n = 1; wr_en_n = 0; addr = a; din = ~d; modify_req = m;
    @(negedge clk);
    addr = ~a;
    repeat (nlow - 1) @(negedge clk);
    wr_en_n = 1; din = d;
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic prot_op(input int sec, input bit hv, input bit set);
    @(negedge clk);
    addr = 17'(sec * 16384); hv_active = hv; prot_set = set; prot_clr = !set;
    @(negedge clk);
    prot_set = 0; prot_clr = 0; hv_active = 0;
  endtask

  task automatic id_rd(input logic [16:0] a, input bit mode, input logic [7:0] exp,
                       input string tag);
    @(negedge clk);
    id_mode = mode; chip_sel_n = 0; out_en_n = 0; addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
    idle(); id_mode = 0;
  endtask

  initial begin
    int v0, r0;
    // R4: power-up with a write low phase already present.
    chip_sel_n = 0; out_en_n = 1; wr_en_n = 0; addr = 17'h00111; din = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R4 reset cmd_valid", cmd_valid, 0);
    chk("R4 reset rd_data", rd_data, 0);
    repeat (4) @(negedge clk);
    chk("R4 hold while strobe low", dec_hold, 1);
    v0 = valid_seen;
    wr_en_n = 1;
    repeat (3) @(negedge clk);
    chk("R4 no write from power-up phase", valid_seen - v0, 0);
    chk("R4 hold released", dec_hold, 0);
    idle();

    // R2/R3: boundary of the minimum low time.
    v0 = valid_seen; wr(17'h01234, 8'hA5, MIN_LOW, 0);
    chk("R2 exact minimum accepted", valid_seen - v0, 1);
    v0 = valid_seen; wr(17'h1F00F, 8'h3C, MIN_LOW - 1, 0);
    chk("R2 short pulse dropped", valid_seen - v0, 0);
    v0 = valid_seen; wr(17'h0ABCD, 8'h77, 1, 0);
    chk("R2 one clock dropped", valid_seen - v0, 0);
    v0 = valid_seen; wr(17'h15555, 8'hC3, 6, 0);
    chk("R3 long pulse single write", valid_seen - v0, 1);

    // R1: chip select high or output enable low during the low phase.
    v0 = valid_seen;
    @(negedge clk); chip_sel_n = 0; wr_en_n = 0; addr = 17'h00200;
    repeat (2) @(negedge clk); chip_sel_n = 1;
    repeat (3) @(negedge clk); wr_en_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 chip select abort", valid_seen - v0, 0);
    idle();
    @(negedge clk); chip_sel_n = 0; wr_en_n = 0; addr = 17'h00300;
    repeat (4) @(negedge clk); out_en_n = 0;
    @(negedge clk); wr_en_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 output enable abort", valid_seen - v0, 0);
    idle();
    @(negedge clk); chip_sel_n = 0; out_en_n = 0; wr_en_n = 0;
    repeat (5) @(negedge clk); wr_en_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 output enable low blocks", valid_seen - v0, 0);
    idle();

    // R5: low supply in the middle of a low phase.
    v0 = valid_seen;
    @(negedge clk); chip_sel_n = 0; wr_en_n = 0; addr = 17'h04444;
    repeat (2) @(negedge clk); supply_low = 1;
    repeat (2) @(negedge clk);
    chk("R5 hold during low supply", dec_hold, 1);
    supply_low = 0;
    repeat (4) @(negedge clk); wr_en_n = 1;
    repeat (3) @(negedge clk);
    chk("R5 aborted across low supply", valid_seen - v0, 0);
    idle();
    wr(17'h04444, 8'h99, MIN_LOW, 0);
    chk("R5 writes resume", valid_seen - v0, 1);

    // R6/R8: protection flags and identification codes.
    id_rd(17'h00000, 1, 8'h01, "R8 manufacturer code");
    id_rd(17'h00001, 1, 8'h20, "R8 device code");
    id_rd(17'h0C002, 1, 8'h00, "R6 sector 3 clear after reset");
    prot_op(3, 0, 1);
    id_rd(17'h0C002, 1, 8'h00, "R6 set ignored without hv");
    prot_op(3, 1, 1);
    id_rd(17'h0C002, 1, 8'h01, "R6 sector 3 protected");
    id_rd(17'h08002, 1, 8'h00, "R6 sector 2 untouched");
    id_rd(17'h0C003, 1, 8'h00, "R8 code 11 reads zero");
    id_rd(17'h00040, 1, 8'h00, "R8 a6 high reads zero");
    id_rd(17'h00001, 0, 8'h00, "R9 no identification outside mode");

    // R7: modify write into protected and unprotected sectors.
    v0 = valid_seen; r0 = reject_seen;
    wr(17'h0C010, 8'h11, MIN_LOW, 1);
    chk("R7 protected modify rejected", reject_seen - r0, 1);
    chk("R7 protected modify no valid", valid_seen - v0, 0);
    wr(17'h0C010, 8'h22, MIN_LOW, 0);
    chk("R7 plain write passes", valid_seen - v0, 1);
    wr(17'h10010, 8'h33, MIN_LOW, 1);
    chk("R7 unprotected modify passes", valid_seen - v0, 2);
    prot_op(3, 0, 0);
    id_rd(17'h0C002, 1, 8'h01, "R6 clear ignored without hv");
    prot_op(3, 1, 0);
    id_rd(17'h0C002, 1, 8'h00, "R6 sector 3 cleared");
    r0 = reject_seen;
    wr(17'h0C010, 8'h44, MIN_LOW, 1);
    chk("R7 no reject after clear", reject_seen - r0, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule